// File: doc/BRIEF.md
# Timestamp Event and Capture Unit

This block sits beside a free-running 64-bit time base and turns time-related occurrences into sticky event flags and one interrupt line. Two alarm comparators watch the running time and flag the cycle on which it equals a programmed 64-bit value. Two asynchronous trigger inputs are synchronized, and on the selected edge the current time is latched into a 64-bit capture register. Three periodic-pulse strobes from an external pulse generator are also recorded.

Every source sets its own bit in an event register. Software acknowledges a bit by writing a one to it. A mask register with the same bit layout decides which pending bits raise the interrupt. A word-wide register port lets software program the alarms and read back the captures as two 32-bit halves. The same port also reaches the control register, which holds the trigger edge selects and the alarm output polarities.

Top module: `ts_event_unit`

## Requirements
- R1: A selected edge on trigger 0 sets event bit 24, and one on trigger 1 sets event bit 25.
- R2: An alarm value is committed by writing its high word. Alarm 0 sets event bit 16 and alarm 1 sets event bit 17 when the time equals the committed value. The alarm fires once per commit, even if the time stays equal. The committed value reads back at its two word addresses.
- R3: Pulse strobe 0 sets event bit 7, strobe 1 sets bit 6 and strobe 2 sets bit 5.
- R4: Writing the event register (word 1) clears every bit written as one and leaves the bits written as zero. An event arriving in the same cycle as its clear stays set.
- R5: The mask register (word 2) uses the event bit layout and reads back only the implemented bits (0x030300E0 when all are written). The irq output is high exactly when some pending event has its mask bit set.
- R6: Control bit 8 selects the capture edge of trigger 0 and bit 9 that of trigger 1, where 0 means rising and 1 means falling. The other edge causes no capture and sets no event.
- R7: A capture stores the full 64-bit time. The high word reads at word 7 (trigger 0) or 9 (trigger 1), and the low word at word 8 or 10. A later capture overwrites an earlier one that is still pending.
- R8: Writing only the low word of an alarm (word 3 for alarm 0, word 5 for alarm 1) leaves the committed value and its comparison unchanged. The high words sit at words 4 and 6.
- R9: Each alarm output pulses for one cycle, in the cycle after its match. Control bit 31 (alarm 0) and bit 30 (alarm 1) invert the output, so a set bit gives an idle-high, active-low pulse.
- R10: A trigger edge passes through a two-flop synchronizer. The event bit and capture appear after the third rising clock edge following the input change, and not before.
- R11: After reset the event, mask, alarm and capture registers read zero, irq is low and both alarm outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| time_now | input | 64 | Current time from the external time base |
| trig_in | input | 2 | Asynchronous external trigger inputs |
| pulse_in | input | 3 | Single-cycle periodic-pulse strobes |
| reg_wen | input | 1 | Register write enable |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| alarm_out | output | 2 | Polarity-controlled alarm pulses |
| irq | output | 1 | OR of masked pending events |

## Verification
The hardest situation to reach from the ports is an alarm match that follows a half-written value. First a distant alarm is committed. Then only a new low word equal to the present time is written, and the bench shows that nothing fires and the old value still reads back. The high-word write that follows must then fire exactly once, while the time is held equal for many cycles. Trigger latency is pinned down by reading the event register on each of the three edges after the input change, with the time held steady so that the captured value is unambiguous.

// File: rtl/tseu_pkg.sv
package tseu_pkg;
   // Event register bit positions (software decodes these)
   localparam int EV_TRIG_LSB   = 24;
   localparam int EV_ALARM_LSB  = 16;
   localparam int EV_PULSE_MSB  = 7;
   // Control register bit positions
   localparam int CTRL_EDGE_LSB = 8;
   localparam int CTRL_APOL_MSB = 31;
   // Word addresses; alarms and captures follow in pairs
   localparam int REG_CTRL       = 0;
   localparam int REG_EVENT      = 1;
   localparam int REG_MASK       = 2;
   localparam int REG_ALARM_BASE = 3;

   function automatic logic [31:0] event_bits(input int n_trig, input int n_alarm,
                                              input int n_pulse);
      logic [31:0] m;
      m = '0;
      for (int i = 0; i < n_trig; i++)  m[EV_TRIG_LSB + i]  = 1'b1;
      for (int i = 0; i < n_alarm; i++) m[EV_ALARM_LSB + i] = 1'b1;
      for (int i = 0; i < n_pulse; i++) m[EV_PULSE_MSB - i] = 1'b1;
      return m;
   endfunction

   function automatic logic [31:0] ctrl_bits(input int n_trig, input int n_alarm);
      logic [31:0] m;
      m = '0;
      for (int i = 0; i < n_trig; i++)  m[CTRL_EDGE_LSB + i] = 1'b1;
      for (int i = 0; i < n_alarm; i++) m[CTRL_APOL_MSB - i] = 1'b1;
      return m;
   endfunction
endpackage

// File: rtl/tseu_trig_capture.sv
module tseu_trig_capture #(
   parameter int TIME_W      = 64,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              trig_async,
   input  logic              fall_sel,
   input  logic [TIME_W-1:0] time_now,
   output logic              cap_stb,
   output logic [TIME_W-1:0] cap_val
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("tseu_trig_capture: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   lvl;

   assign lvl = sync_q[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], trig_async};
         prev_q <= lvl;
      end
   end

   assign cap_stb = fall_sel ? (prev_q & ~lvl) : (lvl & ~prev_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cap_val <= '0;
      else if (cap_stb) cap_val <= time_now;
   end

   // R10
   edge_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cap_stb |=> !cap_stb);
   // R6
   edge_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cap_stb |=> (prev_q != $past(fall_sel)));
   // R7
   cap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cap_stb |=> (cap_val == $past(time_now)));
endmodule

// File: rtl/tseu_alarm_cmp.sv
module tseu_alarm_cmp #(
   parameter int TIME_W = 64,
   parameter int BUS_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic [BUS_W-1:0]  wdata,
   input  logic [TIME_W-1:0] time_now,
   output logic              hit,
   output logic [TIME_W-1:0] alarm_val
);
   generate
      if (TIME_W != 2 * BUS_W) begin : g_bad_width
         $error("tseu_alarm_cmp: TIME_W must be twice BUS_W");
      end
   endgenerate

   logic [BUS_W-1:0]  lo_stage_q;
   logic [TIME_W-1:0] alarm_q;
   logic              armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     lo_stage_q <= '0;
      else if (wr_lo) lo_stage_q <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         alarm_q <= '0;
         armed_q <= 1'b0;
      end else if (wr_hi) begin
         alarm_q <= {wdata, lo_stage_q};
         armed_q <= 1'b1;
      end else if (hit) begin
         armed_q <= 1'b0;
      end
   end

   assign hit       = armed_q && (time_now == alarm_q);
   assign alarm_val = alarm_q;

   // R8
   lo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_lo && !wr_hi) |=> $stable(alarm_q));
   // R2
   one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !wr_hi) |=> !hit);
   // R2
   commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hi |=> (alarm_q[TIME_W-1:BUS_W] == $past(wdata)));
endmodule

// File: rtl/tseu_event_bank.sv
module tseu_event_bank #(
   parameter int               BUS_W = 32,
   parameter logic [BUS_W-1:0] VALID = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [BUS_W-1:0] ev_set,
   input  logic             ev_wr,
   input  logic             mask_wr,
   input  logic [BUS_W-1:0] wdata,
   output logic [BUS_W-1:0] ev_q,
   output logic [BUS_W-1:0] mask_q,
   output logic             irq
);
   logic [BUS_W-1:0] clr;

   assign clr = ev_wr ? (wdata & VALID) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ev_q   <= '0;
         mask_q <= '0;
      end else begin
         ev_q <= ((ev_q & ~clr) | ev_set) & VALID;
         if (mask_wr) mask_q <= wdata & VALID;
      end
   end

   assign irq = |(ev_q & mask_q);

   // R4
   clr_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((clr & ~ev_set) != '0) |=> ((ev_q & $past(clr & ~ev_set)) == '0));
   // R4
   sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((ev_set & VALID) != '0) |=> ((ev_q & $past(ev_set & VALID)) == $past(ev_set & VALID)));
   // R5
   irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(irq) && irq) |-> ($past(ev_set) != '0 || $past(mask_wr)));
endmodule

// File: rtl/ts_event_unit.sv
module ts_event_unit
   import tseu_pkg::*;
#(
   parameter int TIME_W      = 64,
   parameter int BUS_W       = 32,
   parameter int ADDR_W      = 4,
   parameter int N_TRIG      = 2,
   parameter int N_ALARM     = 2,
   parameter int N_PULSE     = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [TIME_W-1:0]  time_now,
   input  logic [N_TRIG-1:0]  trig_in,
   input  logic [N_PULSE-1:0] pulse_in,
   input  logic               reg_wen,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic [BUS_W-1:0]   reg_wdata,
   output logic [BUS_W-1:0]   reg_rdata,
   output logic [N_ALARM-1:0] alarm_out,
   output logic               irq
);
   localparam int          CAP_BASE   = REG_ALARM_BASE + 2 * N_ALARM;
   localparam int          LAST_ADDR  = CAP_BASE + 2 * N_TRIG - 1;
   localparam logic [31:0] EV_VALID   = event_bits(N_TRIG, N_ALARM, N_PULSE);
   localparam logic [31:0] CTRL_VALID = ctrl_bits(N_TRIG, N_ALARM);

   generate
      if (BUS_W != 32) begin : g_bad_bus
         $error("ts_event_unit: BUS_W must be 32");
      end
      if (TIME_W != 2 * BUS_W) begin : g_bad_time
         $error("ts_event_unit: TIME_W must be twice BUS_W");
      end
      if (N_TRIG < 1 || N_TRIG > 8 || N_ALARM < 1 || N_ALARM > 8) begin : g_bad_count
         $error("ts_event_unit: trigger and alarm counts must be 1..8");
      end
      if (N_PULSE < 1 || N_PULSE > 8) begin : g_bad_pulse
         $error("ts_event_unit: pulse count must be 1..8");
      end
      if (LAST_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
         $error("ts_event_unit: ADDR_W too narrow for the register map");
      end
   endgenerate

   logic [BUS_W-1:0]   ctrl_q;
   logic [BUS_W-1:0]   ev_set;
   logic [BUS_W-1:0]   ev_q;
   logic [BUS_W-1:0]   mask_q;
   logic               wr_ctrl;
   logic               wr_event;
   logic               wr_mask;
   logic [N_ALARM-1:0] hit;
   logic [N_ALARM-1:0] alarm_hit_q;
   logic [TIME_W-1:0]  alarm_val [N_ALARM];
   logic [N_TRIG-1:0]  cap_stb;
   logic [TIME_W-1:0]  cap_val [N_TRIG];

   assign wr_ctrl  = reg_wen && (reg_addr == ADDR_W'(REG_CTRL));
   assign wr_event = reg_wen && (reg_addr == ADDR_W'(REG_EVENT));
   assign wr_mask  = reg_wen && (reg_addr == ADDR_W'(REG_MASK));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctrl_q <= '0;
      else if (wr_ctrl) ctrl_q <= reg_wdata & CTRL_VALID;
   end

   // Alarm comparators and their polarity-controlled outputs
   generate
      for (genvar a = 0; a < N_ALARM; a++) begin : g_alarm
         localparam int LO_ADDR = REG_ALARM_BASE + 2 * a;
         logic wr_lo;
         logic wr_hi;

         assign wr_lo = reg_wen && (reg_addr == ADDR_W'(LO_ADDR));
         assign wr_hi = reg_wen && (reg_addr == ADDR_W'(LO_ADDR + 1));

         tseu_alarm_cmp #(
            .TIME_W (TIME_W),
            .BUS_W  (BUS_W)
         ) u_cmp (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_lo     (wr_lo),
            .wr_hi     (wr_hi),
            .wdata     (reg_wdata),
            .time_now  (time_now),
            .hit       (hit[a]),
            .alarm_val (alarm_val[a])
         );

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) alarm_hit_q[a] <= 1'b0;
            else        alarm_hit_q[a] <= hit[a];
         end

         assign alarm_out[a] = alarm_hit_q[a] ^ ctrl_q[CTRL_APOL_MSB - a];

         // R9
         alarm_pol_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (hit[a] && !wr_ctrl) |=> (alarm_out[a] != ctrl_q[CTRL_APOL_MSB - a]));
      end
   endgenerate

   // External trigger capture channels
   generate
      for (genvar t = 0; t < N_TRIG; t++) begin : g_trig
         tseu_trig_capture #(
            .TIME_W      (TIME_W),
            .SYNC_STAGES (SYNC_STAGES)
         ) u_cap (
            .clk        (clk),
            .rst_n      (rst_n),
            .trig_async (trig_in[t]),
            .fall_sel   (ctrl_q[CTRL_EDGE_LSB + t]),
            .time_now   (time_now),
            .cap_stb    (cap_stb[t]),
            .cap_val    (cap_val[t])
         );
      end
   endgenerate

   always_comb begin
      ev_set = '0;
      for (int t = 0; t < N_TRIG; t++)  ev_set[EV_TRIG_LSB + t]  = cap_stb[t];
      for (int a = 0; a < N_ALARM; a++) ev_set[EV_ALARM_LSB + a] = hit[a];
      for (int p = 0; p < N_PULSE; p++) ev_set[EV_PULSE_MSB - p] = pulse_in[p];
   end

   tseu_event_bank #(
      .BUS_W (BUS_W),
      .VALID (EV_VALID)
   ) u_events (
      .clk     (clk),
      .rst_n   (rst_n),
      .ev_set  (ev_set),
      .ev_wr   (wr_event),
      .mask_wr (wr_mask),
      .wdata   (reg_wdata),
      .ev_q    (ev_q),
      .mask_q  (mask_q),
      .irq     (irq)
   );

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == ADDR_W'(REG_CTRL))  reg_rdata = ctrl_q;
      if (reg_addr == ADDR_W'(REG_EVENT)) reg_rdata = ev_q;
      if (reg_addr == ADDR_W'(REG_MASK))  reg_rdata = mask_q;
      for (int a = 0; a < N_ALARM; a++) begin
         if (reg_addr == ADDR_W'(REG_ALARM_BASE + 2 * a))
            reg_rdata = alarm_val[a][BUS_W-1:0];
         if (reg_addr == ADDR_W'(REG_ALARM_BASE + 2 * a + 1))
            reg_rdata = alarm_val[a][TIME_W-1:BUS_W];
      end
      for (int t = 0; t < N_TRIG; t++) begin
         if (reg_addr == ADDR_W'(CAP_BASE + 2 * t))
            reg_rdata = cap_val[t][TIME_W-1:BUS_W];
         if (reg_addr == ADDR_W'(CAP_BASE + 2 * t + 1))
            reg_rdata = cap_val[t][BUS_W-1:0];
      end
   end

   // R1
   trig_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_stb[0] && !wr_event) |=> ev_q[EV_TRIG_LSB]);
endmodule

// File: tb/ts_event_unit_bench.sv
module ts_event_unit_bench;
   localparam logic [3:0] A_CTRL = 4'd0, A_EV = 4'd1, A_MASK = 4'd2;
   localparam logic [3:0] A_AL0L = 4'd3, A_AL0H = 4'd4, A_AL1L = 4'd5, A_AL1H = 4'd6;
   localparam logic [3:0] A_C0H = 4'd7, A_C0L = 4'd8, A_C1H = 4'd9, A_C1L = 4'd10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] time_now = '0;
   logic [1:0]  trig_in = '0;
   logic [2:0]  pulse_in = '0;
   logic        reg_wen = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [1:0]  alarm_out;
   logic        irq;

   always #5 clk = ~clk;

   ts_event_unit u_ts_event_unit (
      .clk       (clk),
      .rst_n     (rst_n),
      .time_now  (time_now),
      .trig_in   (trig_in),
      .pulse_in  (pulse_in),
      .reg_wen   (reg_wen),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .alarm_out (alarm_out),
      .irq       (irq)
   );

   typedef struct {
      int          sel;
      logic [31:0] exp;
      string       req;
   } item_t;

   item_t sb_q[$];
   int    req_seq = 0;
   int    ack_seq = 0;
   int    checks  = 0;
   int    errors  = 0;
   bit    done    = 1'b0;

   // Monitor: pops one expected item per request and compares
   always @(negedge clk) begin
      if (req_seq != ack_seq) begin
         item_t       it;
         logic [31:0] act;
         it = sb_q.pop_front();
         case (it.sel)
            0:       act = reg_rdata;
            1:       act = {31'b0, irq};
            default: act = {30'b0, alarm_out};
         endcase
         checks++;
         if (act !== it.exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", it.req, act, it.exp);
         end
         ack_seq++;
      end
   end

   task automatic expect_val(input int sel, input logic [3:0] addr,
                             input logic [31:0] exp, input string req);
      item_t it;
      @(posedge clk); #1;
      reg_addr = addr;
      it.sel = sel;
      it.exp = exp;
      it.req = req;
      sb_q.push_back(it);
      req_seq++;
      @(negedge clk); #1;
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(posedge clk); #1;
      reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk); #1;
      reg_wen = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic pulse(input logic [2:0] p);
      @(posedge clk); #1; pulse_in = p;
      @(posedge clk); #1; pulse_in = '0;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL R11 watchdog actual hung expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R11 reset state
      expect_val(0, A_EV,   32'h0, "R11 event after reset");
      expect_val(0, A_MASK, 32'h0, "R11 mask after reset");
      expect_val(0, A_C0L,  32'h0, "R11 capture after reset");
      expect_val(0, A_AL0H, 32'h0, "R11 alarm after reset");
      expect_val(1, A_EV,   32'h0, "R11 irq after reset");
      expect_val(2, A_EV,   32'h0, "R11 alarm_out after reset");

      // R3 pulse strobes
      pulse(3'b001);
      expect_val(0, A_EV, 32'h80, "R3 pulse 0 to bit 7");
      pulse(3'b110);
      expect_val(0, A_EV, 32'hE0, "R3 pulses 1,2 to bits 6,5");

      // R4 write-one-to-clear
      wr(A_EV, 32'h40);
      expect_val(0, A_EV, 32'hA0, "R4 clear one bit");
      wr(A_EV, 32'h0);
      expect_val(0, A_EV, 32'hA0, "R4 zero write keeps bits");
      wr(A_EV, 32'hFFFF_FFFF);
      expect_val(0, A_EV, 32'h0, "R4 clear all");
      @(posedge clk); #1;
      reg_wen = 1'b1; reg_addr = A_EV; reg_wdata = 32'h80; pulse_in = 3'b001;
      @(posedge clk); #1;
      reg_wen = 1'b0; pulse_in = '0;
      expect_val(0, A_EV, 32'h80, "R4 set wins over clear");
      wr(A_EV, 32'h80);

      // R5 mask and irq
      pulse(3'b010);
      expect_val(1, A_EV, 32'h0, "R5 unmasked event no irq");
      wr(A_MASK, 32'h40);
      expect_val(1, A_EV, 32'h1, "R5 masked event raises irq");
      wr(A_MASK, 32'h80);
      expect_val(1, A_EV, 32'h0, "R5 other mask bit no irq");
      wr(A_MASK, 32'hFFFF_FFFF);
      expect_val(0, A_MASK, 32'h0303_00E0, "R5 mask implemented bits");
      expect_val(1, A_EV, 32'h1, "R5 irq with full mask");
      wr(A_EV, 32'h40);
      expect_val(1, A_EV, 32'h0, "R5 irq drops on clear");
      wr(A_MASK, 32'h0);

      // R10 / R1 trigger 0 rising capture latency
      time_now = 64'h1122_3344_5566_7788;
      @(posedge clk); #1; trig_in[0] = 1'b1;
      expect_val(0, A_EV, 32'h0, "R10 not after first edge");
      expect_val(0, A_EV, 32'h0, "R10 not after second edge");
      expect_val(0, A_EV, 32'h0100_0000, "R10 R1 set after third edge");
      expect_val(0, A_C0H, 32'h1122_3344, "R7 capture high");
      expect_val(0, A_C0L, 32'h5566_7788, "R7 capture low");

      // R6 falling edge ignored, R7 overwrite while pending
      time_now = 64'hAAAA_0000_0000_0001;
      trig_in[0] = 1'b0;
      idle(5);
      expect_val(0, A_C0L, 32'h5566_7788, "R6 falling edge ignored");
      trig_in[0] = 1'b1;
      idle(5);
      expect_val(0, A_C0H, 32'hAAAA_0000, "R7 overwrite high");
      expect_val(0, A_C0L, 32'h0000_0001, "R7 overwrite low");

      // R6 trigger 1 on falling edge
      wr(A_CTRL, 32'h200);
      expect_val(0, A_CTRL, 32'h200, "R6 edge select readback");
      trig_in[1] = 1'b1;
      idle(5);
      expect_val(0, A_EV, 32'h0100_0000, "R6 rising ignored on falling select");
      time_now = 64'h0BAD_F00D_CAFE_0042;
      trig_in[1] = 1'b0;
      idle(5);
      expect_val(0, A_EV, 32'h0300_0000, "R1 R6 trigger 1 to bit 25");
      expect_val(0, A_C1H, 32'h0BAD_F00D, "R7 capture 1 high");
      expect_val(0, A_C1L, 32'hCAFE_0042, "R7 capture 1 low");
      wr(A_EV, 32'hFFFF_FFFF);

      // R8 / R2 alarm 0
      time_now = 64'd100;
      wr(A_AL0L, 32'd500);
      wr(A_AL0H, 32'd0);
      wr(A_AL0L, 32'd100);
      idle(3);
      expect_val(0, A_EV,   32'h0,    "R8 low write alone no match");
      expect_val(0, A_AL0L, 32'd500,  "R8 committed value unchanged");
      wr(A_AL0H, 32'd0);
      expect_val(2, A_EV, 32'h1, "R9 R2 alarm 0 pulse");
      expect_val(2, A_EV, 32'h0, "R2 alarm 0 one cycle only");
      expect_val(0, A_EV, 32'h0001_0000, "R2 alarm 0 to bit 16");
      wr(A_EV, 32'hFFFF_FFFF);
      idle(3);
      expect_val(0, A_EV, 32'h0, "R2 no refire while time equal");

      // R9 / R2 alarm 1 with inverted output
      wr(A_CTRL, 32'h4000_0200);
      expect_val(2, A_EV, 32'h2, "R9 inverted output idles high");
      wr(A_AL1L, 32'd7);
      wr(A_AL1H, 32'd5);
      expect_val(0, A_AL1L, 32'd7, "R2 alarm 1 low readback");
      expect_val(0, A_AL1H, 32'd5, "R2 alarm 1 high readback");
      wr(A_MASK, 32'h0002_0000);
      @(posedge clk); #1;
      time_now = 64'h0000_0005_0000_0007;
      expect_val(2, A_EV, 32'h0, "R9 active-low alarm pulse");
      expect_val(2, A_EV, 32'h2, "R9 returns to idle high");
      expect_val(0, A_EV, 32'h0002_0000, "R2 alarm 1 to bit 17");
      expect_val(1, A_EV, 32'h1, "R5 alarm event raises irq");

      idle(2);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule